// File: doc/BRIEF.md
# Transceiver Tx/Rx Reset Sequencer

This block brings up a serial transceiver whose internal transmit and receive elastic buffers are bypassed, so that the surrounding logic, not the transceiver, must order the resets. After system reset is released it sends a one-cycle reset pulse to the transmit side. It then waits, with no time limit, for the transceiver's transmit reset-done flag, and at that point declares the transmit user path ready.

The receive side follows only after that. A one-cycle receive reset pulse is sent, the machine waits for receive reset-done, and then the receive user path is declared ready. The two reset-done flags arrive asynchronously from the transceiver. Each passes through its own chain of synchroniser flops before the state machine looks at it.

All pins are plain control and status levels. There is no streaming data interface, so no valid/ready rules apply. A system reset at any moment clears the machine and both ready outputs, and the whole sequence starts again.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `tx_rst`, `rx_rst`, `tx_user_rdy` and `rx_user_rdy` are all 0.
- R2: Counting rising edges after `rst_n` is released as 1, 2, 3 and so on, `tx_rst` is 1 only after edge 1, for exactly one cycle, and is never asserted again until the next reset.
- R3: Each done input passes through SYNC_STAGES (default 2) flops. If `tx_done` first goes high between edge a and edge a+1 (a=0 meaning it was high before release), `tx_user_rdy` becomes 1 after edge T = max(a,0)+3.
- R4: `rx_rst` is 1 for exactly one cycle, after edge T, which is the same cycle in which `tx_user_rdy` first becomes 1. It is never 1 while `tx_user_rdy` is 0.
- R5: If `rx_done` first goes high between edge b and edge b+1, `rx_user_rdy` becomes 1 after edge R = max(b+3, T+2). It is never 1 while `tx_user_rdy` is 0.
- R6: A done flag that is already high when its wait begins is accepted with no extra delay. A done flag that stays low holds the machine in its wait indefinitely, with no timeout.
- R7: Once set, `tx_user_rdy` and `rx_user_rdy` stay 1 until the next reset. Dropping `tx_done` or `rx_done` afterwards has no effect on any output.
- R8: A reset asserted mid-sequence clears all outputs. After release, the sequence restarts from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tx_done | input | 1 | Transmit reset-done from transceiver, asynchronous |
| rx_done | input | 1 | Receive reset-done from transceiver, asynchronous |
| tx_rst | output | 1 | Transmit reset pulse to transceiver |
| rx_rst | output | 1 | Receive reset pulse to transceiver |
| tx_user_rdy | output | 1 | Transmit user path released |
| rx_user_rdy | output | 1 | Receive user path released |

## Verification
A wrong internal state is visible at the ports within one cycle, because every output decodes the state register directly. A stuck or skipped state shows up as a missing or doubled reset pulse, or as a ready signal that rises on the wrong edge. A synchroniser that is too long or too short moves the ready edge by a whole cycle, so every cycle of the sequence is compared against the arithmetic edge numbers T and R. This comparison is repeated across a sweep of done-arrival times for both directions.

// File: rtl/xcvr_rst_seq_pkg.sv
package xcvr_rst_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE     = 3'd0,
    SEQ_TX_PULSE = 3'd1,
    SEQ_TX_WAIT  = 3'd2,
    SEQ_RX_PULSE = 3'd3,
    SEQ_RX_WAIT  = 3'd4,
    SEQ_UP       = 3'd5
  } seq_state_e;
endpackage

// File: rtl/xcvr_rst_seq_sync.sv
module xcvr_rst_seq_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [SYNC_STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= d_async;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_sync = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/xcvr_rst_seq_fsm.sv
module xcvr_rst_seq_fsm
  import xcvr_rst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_done_s,
  input  logic rx_done_s,
  output logic tx_rst,
  output logic rx_rst,
  output logic tx_user_rdy,
  output logic rx_user_rdy
);
  seq_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE:     state_d = SEQ_TX_PULSE;
      SEQ_TX_PULSE: state_d = SEQ_TX_WAIT;
      SEQ_TX_WAIT:  if (tx_done_s) state_d = SEQ_RX_PULSE;
      SEQ_RX_PULSE: state_d = SEQ_RX_WAIT;
      SEQ_RX_WAIT:  if (rx_done_s) state_d = SEQ_UP;
      SEQ_UP:       state_d = SEQ_UP;
      default:      state_d = SEQ_IDLE;
    endcase
  end

  assign tx_rst      = (state_q == SEQ_TX_PULSE);
  assign rx_rst      = (state_q == SEQ_RX_PULSE);
  assign tx_user_rdy = (state_q == SEQ_RX_PULSE) || (state_q == SEQ_RX_WAIT) ||
                       (state_q == SEQ_UP);
  assign rx_user_rdy = (state_q == SEQ_UP);
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_done,
  input  logic rx_done,
  output logic tx_rst,
  output logic rx_rst,
  output logic tx_user_rdy,
  output logic rx_user_rdy
);
  localparam int NUM_DIR = 2;

  logic [NUM_DIR-1:0] done_async;
  logic [NUM_DIR-1:0] done_sync;

  assign done_async = {rx_done, tx_done};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_sync
    xcvr_rst_seq_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (done_async[d]),
      .q_sync  (done_sync[d])
    );
  end

  xcvr_rst_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_done_s   (done_sync[0]),
    .rx_done_s   (done_sync[1]),
    .tx_rst      (tx_rst),
    .rx_rst      (rx_rst),
    .tx_user_rdy (tx_user_rdy),
    .rx_user_rdy (rx_user_rdy)
  );
endmodule

// File: rtl/xcvr_rst_seq_chk.sv
module xcvr_rst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_done_s,
  input logic rx_done_s,
  input logic tx_rst,
  input logic rx_rst,
  input logic tx_user_rdy,
  input logic rx_user_rdy
);
  assert_tx_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> !tx_rst);

  assert_rx_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> !rx_rst);

  assert_rx_pulse_after_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |-> tx_user_rdy);

  assert_rx_rdy_after_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_user_rdy |-> tx_user_rdy);

  assert_tx_rdy_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_user_rdy) |-> $past(tx_done_s));

  assert_rx_rdy_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_user_rdy) |-> $past(rx_done_s));

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_user_rdy && rx_user_rdy) |=> (tx_user_rdy && rx_user_rdy));

  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_rst, rx_rst}));
endmodule

bind xcvr_rst_seq xcvr_rst_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_done_s   (done_sync[0]),
  .rx_done_s   (done_sync[1]),
  .tx_rst      (tx_rst),
  .rx_rst      (rx_rst),
  .tx_user_rdy (tx_user_rdy),
  .rx_user_rdy (rx_user_rdy)
);

// File: tb/xcvr_rst_seq_tb_top.sv
`timescale 1ns/1ps
module xcvr_rst_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_done = 1'b0;
  logic rx_done = 1'b0;
  logic tx_rst, rx_rst, tx_user_rdy, rx_user_rdy;

  int n_vec  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  xcvr_rst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .rx_done(rx_done),
    .tx_rst(tx_rst), .rx_rst(rx_rst),
    .tx_user_rdy(tx_user_rdy), .rx_user_rdy(rx_user_rdy)
  );

  task automatic cmp(input string req, input int cyc, input logic [3:0] act,
                     input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: {tx_rst,rx_rst,tx_rdy,rx_rdy} actual %b expected %b",
               req, cyc, act, exp);
    end
  endtask

  task automatic do_reset(input logic tx_pre);
    @(negedge clk);
    rst_n = 1'b0;
    tx_done = tx_pre;
    rx_done = 1'b0;
    @(negedge clk);
    cmp("R1/R8", -1, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // a: cycle after which tx_done rises (0 = before release), b likewise for rx_done
  task automatic run_seq(input int a, input int b);
    int t_edge, r_edge, last;
    logic [3:0] exp;
    t_edge = a + 3;
    r_edge = (b + 3 > t_edge + 2) ? b + 3 : t_edge + 2;
    last = r_edge + 3;
    do_reset(a == 0);
    if (b == 0) rx_done = 1'b1;
    cmp("R1", 0, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, 4'b0000);
    for (int c = 1; c <= last; c++) begin
      @(posedge clk);
      @(negedge clk);
      exp = {c == 1, c == t_edge, c >= t_edge, c >= r_edge};
      if (c == 1) cmp("R2", c, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, exp);
      else if (c <= t_edge) cmp("R3/R6", c, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, exp);
      else cmp("R4/R5", c, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, exp);
      if (c == a) tx_done = 1'b1;
      if (c == b) rx_done = 1'b1;
    end
    // R7: drop both flags, outputs must hold
    tx_done = 1'b0;
    rx_done = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      cmp("R7", last + k + 1, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, 4'b0011);
    end
  endtask

  initial begin
    for (int a = 0; a <= 6; a++)
      for (int b = 0; b <= 12; b++)
        run_seq(a, b);

    // R6: tx_done never arrives, machine must keep waiting
    do_reset(1'b0);
    for (int c = 1; c <= 40; c++) begin
      @(posedge clk);
      @(negedge clk);
      cmp("R6", c, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, {c == 1, 3'b000});
    end

    // R8: reset in the middle of the receive wait, then a full restart
    tx_done = 1'b1;
    for (int c = 0; c < 6; c++) @(negedge clk);
    cmp("R8", 0, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, 4'b0010);
    rst_n = 1'b0;
    #1;
    cmp("R1/R8", 0, {tx_rst, rx_rst, tx_user_rdy, rx_user_rdy}, 4'b0000);
    run_seq(2, 4);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule